// File: doc/BRIEF.md
# Dual-Interface Transmit Word Serializer

This block takes 8b/10b code groups from a protocol device and emits them as a serial stream, one bit per bit-clock cycle. The bit clock runs ten times faster than the word clock. The word clock is built inside the block by a divide-by-ten phase counter, and the block drives it out on `word_clk` so that the protocol device can launch data against it. `word_clk` is high for phases 0 to 4 and low for phases 5 to 9.

Two parallel front ends are available. In wide mode, all ten data inputs are sampled on the rising edge of the word clock. In narrow mode, only the five low inputs are used: the rising edge supplies code bits 0 to 4, the following falling edge supplies code bits 5 to 9, and the two halves are merged into one word. A test enable replaces the parallel input with words from a 7-bit maximal-length pattern generator.

The mode and the test enable are sampled only at word boundaries. The first word after an interface change may be discarded.

Top module: `ser_dual_if_tx`

## Requirements
- R1: While `rst` is high on a bit-clock edge, `ser_o` is low after that edge and `word_clk` is high. After release, `ser_o` stays low until the first word taken after release reaches the output.
- R2: After release, `word_clk` repeats every 10 bit clocks: high for 5 cycles, then low for 5. The first rising edge of `word_clk` comes 10 bit clocks after the first edge with `rst` low.
- R3: With `narrow_sel`=0 and `pat_en`=0, all of `tx_data[9:0]` is captured on the bit-clock edge where `word_clk` rises. The word is sent bit 0 first and bit 9 last.
- R4: In wide mode, bit k of a word captured at edge E is on `ser_o` in the bit period that follows edge E+10+k. Bit 9 therefore leaves 19 to 20 bit times after capture.
- R5: With `narrow_sel`=1, `tx_data[4:0]` captured at the `word_clk` rising edge becomes code bits 0 to 4. `tx_data[4:0]` captured at the next falling edge becomes code bits 5 to 9.
- R6: In narrow mode, bit k of a word whose low half is captured at edge E is on `ser_o` after edge E+20+k. Bit 9 therefore leaves 29 to 30 bit times after capture.
- R7: In narrow mode, `tx_data[9:5]` has no effect on the serial stream.
- R8: With `pat_en`=1 at a boundary, the parallel input is ignored and the word holds the next ten outputs of the pattern generator, bit 0 being the earliest. The generator is a 7-bit register s: each step computes b = s[6]^s[5], shifts b in at s[0], and outputs b. It starts at all ones after reset and advances only for words it supplies.
- R9: `narrow_sel` is sampled only at word boundaries, so changes between boundaries alter no word. At a boundary taken in narrow mode, the word emitted is valid only if the previous boundary was also taken in narrow mode. The first word after a change may be lost.
- R10: `pat_en` is sampled only at word boundaries, so toggles between boundaries neither alter words nor advance the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, ten per word |
| rst | input | 1 | Synchronous active-high reset |
| narrow_sel | input | 1 | 0 = 10-bit single-edge input, 1 = 5-bit double-edge input |
| pat_en | input | 1 | Replace parallel input with pattern words |
| tx_data | input | 10 | Parallel code group input |
| word_clk | output | 1 | Word clock derived from the phase counter |
| ser_o | output | 1 | Serial output, bit 0 first |

## Verification
The bench toggles `narrow_sel` and `pat_en` between boundaries and drives junk on `tx_data` at every non-capture edge. A design that samples controls or data off the boundary edge would corrupt words. It puts junk on `tx_data[9:5]` in narrow mode, which exposes a merge that picks up the wrong half or the upper pins. It switches interfaces in both directions and into and out of pattern mode, and checks that the stream resumes at the right latency with the right generator phase. A design whose generator free-runs, or that is off by one word in the narrow path, misplaces whole words. A mid-run reset must clear the word register and reseed the generator, or stale data appears before the first new word.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int unsigned SER_WORD_W = 10;
    localparam int unsigned SER_LFSR_W = 7;
    localparam int unsigned SER_TAP_HI = 6;
    localparam int unsigned SER_TAP_LO = 5;

    typedef enum logic {
        IF_WIDE   = 1'b0,
        IF_NARROW = 1'b1
    } if_mode_e;

    function automatic int unsigned half_of(input int unsigned w);
        return w / 2;
    endfunction

endpackage

// File: rtl/ser_word_timer.sv
module ser_word_timer #(
    parameter int unsigned WORD_W = ser_pkg::SER_WORD_W
) (
    input  logic clk,
    input  logic rst,
    output logic rise_en,
    output logic fall_en,
    output logic word_clk
);
    localparam int unsigned CW   = $clog2(WORD_W);
    localparam int unsigned HALF = ser_pkg::half_of(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF - 1);
    localparam logic [CW-1:0] HI_N = CW'(HALF);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign rise_en  = (phase == LAST);
    assign fall_en  = (phase == MID);
    assign word_clk = (phase < HI_N);

    // R2: the phase wraps after the last slot
    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        rise_en |=> (phase == '0));
    // R2: the phase never leaves its range
    a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);
    // R2: word_clk rises right after a boundary edge
    a_r2_clk_rise: assert property (@(posedge clk) disable iff (rst)
        rise_en |=> word_clk);
endmodule

// File: rtl/ser_prbs_gen.sv
module ser_prbs_gen #(
    parameter int unsigned WORD_W = ser_pkg::SER_WORD_W,
    parameter int unsigned LFSR_W = ser_pkg::SER_LFSR_W,
    parameter int unsigned TAP_HI = ser_pkg::SER_TAP_HI,
    parameter int unsigned TAP_LO = ser_pkg::SER_TAP_LO,
    parameter logic [LFSR_W-1:0] SEED = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [WORD_W-1:0] pat_word
);
    logic [LFSR_W-1:0] state;
    logic [LFSR_W-1:0] nxt;

    always_comb begin
        logic [LFSR_W-1:0] s;
        logic              nb;
        s = state;
        pat_word = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            nb = s[TAP_HI] ^ s[TAP_LO];
            pat_word[i] = nb;
            s = {s[LFSR_W-2:0], nb};
        end
        nxt = s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (adv) begin
            state <= nxt;
        end
    end

    // R8: a maximal-length register never reaches all zeros
    a_r8_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);
    // R10: the generator holds unless a pattern word is taken
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));
endmodule

// File: rtl/ser_front_end.sv
module ser_front_end #(
    parameter int unsigned WORD_W = ser_pkg::SER_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_en,
    input  logic              fall_en,
    input  ser_pkg::if_mode_e mode,
    input  logic              pat_en,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [WORD_W-1:0] pat_word,
    output logic              pat_take,
    output logic [WORD_W-1:0] word_q
);
    localparam int unsigned HALF = ser_pkg::half_of(WORD_W);

    logic [HALF-1:0]   lo_q;
    logic [HALF-1:0]   hi_q;
    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] par_word;

    // Both half registers run in every mode; only the merge is selected.
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (rise_en) lo_q <= tx_data[HALF-1:0];
            if (fall_en) hi_q <= tx_data[HALF-1:0];
        end
    end

    generate
        if (2 * HALF == WORD_W) begin : g_even
            always_comb begin
                if (mode == ser_pkg::IF_NARROW) par_word = {hi_q, lo_q};
                else                            par_word = tx_data;
            end
        end else begin : g_odd
            always_comb begin
                if (mode == ser_pkg::IF_NARROW) par_word = {1'b0, hi_q, lo_q};
                else                            par_word = tx_data;
            end
        end
    endgenerate

    assign next_word = pat_en ? pat_word : par_word;
    assign pat_take  = rise_en & pat_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (rise_en) begin
            word_q <= next_word;
        end
    end

    // R9: the word register moves only at a boundary
    a_r9_word_held: assert property (@(posedge clk) disable iff (rst)
        !rise_en |=> $stable(word_q));
    // R8: a pattern word replaces the parallel input
    a_r8_pattern_wins: assert property (@(posedge clk) disable iff (rst)
        (rise_en && pat_en) |=> (word_q == $past(pat_word)));
    // R5: the half captured at the falling phase lands in the upper bits
    a_r5_upper_half: assert property (@(posedge clk) disable iff (rst)
        (rise_en && !pat_en && mode == ser_pkg::IF_NARROW)
            |=> (word_q[2*HALF-1:HALF] == $past(hi_q)));
endmodule

// File: rtl/ser_shift_out.sv
module ser_shift_out #(
    parameter int unsigned WORD_W = ser_pkg::SER_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_o
);
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= word_i;
        end else begin
            sh <= {1'b0, sh[WORD_W-1:1]};
        end
    end

    assign ser_o = sh[0];

    // R3: bit 0 leaves first, right after the load
    a_r3_bit0_first: assert property (@(posedge clk) disable iff (rst)
        load |=> (ser_o == $past(word_i[0])));
    // R3: bit 1 follows bit 0
    a_r3_bit1_next: assert property (@(posedge clk) disable iff (rst)
        load |=> ##1 (ser_o == $past(word_i[1], 2)));
endmodule

// File: rtl/ser_dual_if_tx.sv
module ser_dual_if_tx #(
    parameter int unsigned WORD_W = ser_pkg::SER_WORD_W,
    parameter int unsigned LFSR_W = ser_pkg::SER_LFSR_W
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic              narrow_sel,
    input  logic              pat_en,
    input  logic [WORD_W-1:0] tx_data,
    output logic              word_clk,
    output logic              ser_o
);
    logic              rise_en;
    logic              fall_en;
    logic              pat_take;
    logic [WORD_W-1:0] pat_word;
    logic [WORD_W-1:0] word_q;
    ser_pkg::if_mode_e mode;

    assign mode = narrow_sel ? ser_pkg::IF_NARROW : ser_pkg::IF_WIDE;

    ser_word_timer #(.WORD_W(WORD_W)) u_timer (
        .clk      (clk_bit),
        .rst      (rst),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .word_clk (word_clk)
    );

    ser_prbs_gen #(.WORD_W(WORD_W), .LFSR_W(LFSR_W)) u_prbs (
        .clk      (clk_bit),
        .rst      (rst),
        .adv      (pat_take),
        .pat_word (pat_word)
    );

    ser_front_end #(.WORD_W(WORD_W)) u_front (
        .clk      (clk_bit),
        .rst      (rst),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .mode     (mode),
        .pat_en   (pat_en),
        .tx_data  (tx_data),
        .pat_word (pat_word),
        .pat_take (pat_take),
        .word_q   (word_q)
    );

    ser_shift_out #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk_bit),
        .rst    (rst),
        .load   (rise_en),
        .word_i (word_q),
        .ser_o  (ser_o)
    );

    // R4: a word taken at one boundary starts leaving at the next
    a_r4_load_follows: assert property (@(posedge clk_bit) disable iff (rst)
        rise_en |=> (ser_o == $past(word_q[0])));
endmodule

// File: tb/ser_dual_if_tx_bench.sv
`timescale 1ns/1ps
module ser_dual_if_tx_bench;
    localparam int NV = 22;
    localparam int NB = NV + 3;
    // fields: [16] narrow, [15] pattern, [14:5] code word, [4:0] junk for upper pins
    localparam logic [16:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 10'h3FF, 5'h00}, {1'b0, 1'b0, 10'h000, 5'h1F},
        {1'b0, 1'b0, 10'h2AA, 5'h15}, {1'b0, 1'b0, 10'h155, 5'h0A},
        {1'b0, 1'b0, 10'h17C, 5'h13}, {1'b0, 1'b0, 10'h283, 5'h0C},
        {1'b1, 1'b0, 10'h0F0, 5'h1F}, {1'b1, 1'b0, 10'h3A5, 5'h00},
        {1'b1, 1'b0, 10'h1C7, 5'h1F}, {1'b1, 1'b0, 10'h2D2, 5'h0E},
        {1'b1, 1'b1, 10'h111, 5'h11}, {1'b1, 1'b1, 10'h222, 5'h1F},
        {1'b1, 1'b0, 10'h099, 5'h05}, {1'b1, 1'b0, 10'h3E1, 5'h1A},
        {1'b0, 1'b0, 10'h24F, 5'h11}, {1'b0, 1'b1, 10'h000, 5'h1F},
        {1'b0, 1'b1, 10'h3FF, 5'h00}, {1'b0, 1'b0, 10'h0A5, 5'h1B},
        {1'b1, 1'b0, 10'h35A, 5'h07}, {1'b1, 1'b0, 10'h1E3, 5'h18},
        {1'b1, 1'b0, 10'h2B4, 5'h03}, {1'b0, 1'b0, 10'h3C3, 5'h1C}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       narrow_sel = 1'b0;
    logic       pat_en = 1'b0;
    logic [9:0] tx_data = '0;
    logic       word_clk;
    logic       ser_o;

    int total = 0;
    int bad = 0;
    logic [6:0] model_s;

    logic [9:0] exp_word [0:NB-1];
    logic       exp_ok   [0:NB-1];
    string      exp_tag  [0:NB-1];

    always #4 clk = ~clk;

    ser_dual_if_tx u_ser_dual_if_tx (
        .clk_bit    (clk),
        .rst        (rst),
        .narrow_sel (narrow_sel),
        .pat_en     (pat_en),
        .tx_data    (tx_data),
        .word_clk   (word_clk),
        .ser_o      (ser_o)
    );

    function automatic logic w_mode(input int b);
        return (b < NV) ? VEC[b][16] : 1'b0;
    endfunction
    function automatic logic w_pat(input int b);
        return (b < NV) ? VEC[b][15] : 1'b0;
    endfunction
    function automatic logic [9:0] w_data(input int b);
        return (b < NV) ? VEC[b][14:5] : 10'h000;
    endfunction
    function automatic logic [4:0] w_junk(input int b);
        return (b < NV) ? VEC[b][4:0] : 5'h15;
    endfunction

    // next ten pattern bits from the model register, bit 0 earliest
    function automatic logic [9:0] model_word();
        logic [9:0] w;
        logic nb;
        for (int i = 0; i < 10; i++) begin
            nb = model_s[6] ^ model_s[5];
            w[i] = nb;
            model_s = {model_s[5:0], nb};
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            // R1: output low, word clock high while reset is held
            check("R1 ser_o in reset", 32'(ser_o), 32'd0);
            check("R1 word_clk in reset", 32'(word_clk), 32'd1);
        end
        rst = 1'b0;
    endtask

    initial begin
        logic [9:0] rx;
        model_s = 7'h7F;
        rx = '0;
        for (int b = 0; b < NB; b++) begin
            exp_ok[b] = 1'b1;
            exp_word[b] = '0;
            if (w_pat(b)) begin
                exp_word[b] = model_word();
                exp_tag[b] = "R8 R10";
            end else if (!w_mode(b)) begin
                exp_word[b] = w_data(b);
                exp_tag[b] = (b > 0 && w_mode(b - 1)) ? "R9 R3 R4" : "R3 R4";
            end else if (b > 0 && w_mode(b - 1)) begin
                exp_word[b] = w_data(b - 1);
                exp_tag[b] = "R5 R6 R7";
            end else begin
                exp_ok[b] = 1'b0;
                exp_tag[b] = "R9";
            end
        end

        hold_reset(4);
        // table walk: sample the output after edge t, drive inputs for edge t+1
        for (int t = 0; t < 10 * NB + 19; t++) begin
            @(negedge clk);
            if (t < 40) begin
                // R2: word clock high in phases 0..4 counted from release
                check("R2 word_clk phase", 32'(word_clk), 32'(((t + 1) % 10) < 5));
            end
            if (t >= 19) begin
                int b;
                int k;
                b = (t - 19) / 10;
                k = (t - 19) % 10;
                rx[k] = ser_o;
                if (k == 9 && exp_ok[b]) begin
                    check($sformatf("%s word %0d", exp_tag[b], b), 32'(rx), 32'(exp_word[b]));
                end
            end
            begin
                int e;
                e = t + 1;
                if (e % 10 == 9) begin
                    int w;
                    w = (e - 9) / 10;
                    narrow_sel = w_mode(w);
                    pat_en = w_pat(w);
                    tx_data = w_mode(w) ? {w_junk(w), w_data(w)[4:0]} : w_data(w);
                end else if (e % 10 == 4 && e >= 14 && w_mode((e - 14) / 10)) begin
                    int w;
                    w = (e - 14) / 10;
                    tx_data = {~w_junk(w), w_data(w)[9:5]};
                    // R9 R10: controls toggle away from the boundary
                    narrow_sel = ~narrow_sel;
                    pat_en = ~pat_en;
                end else begin
                    tx_data = 10'h2C5 ^ 10'(e * 37);
                    narrow_sel = (e % 3 == 0);
                    pat_en = (e % 4 == 1);
                end
            end
        end

        // directed: mid-run reset clears the pipe and reseeds the generator
        hold_reset(3);
        model_s = 7'h7F;
        begin
            logic [9:0] pexp;
            pexp = model_word();
            for (int t = 0; t < 29; t++) begin
                @(negedge clk);
                if (t < 19) begin
                    if (t == 0 || t == 9 || t == 18)
                        check("R1 ser_o low before first word", 32'(ser_o), 32'd0);
                end else begin
                    rx[t - 19] = ser_o;
                end
                if (t == 4 || t == 9) begin
                    // R2: falling edge of word_clk after phase 4, rising after phase 9
                    check("R2 word_clk edge", 32'(word_clk), (t == 4) ? 32'd0 : 32'd1);
                end
                narrow_sel = 1'b0;
                pat_en = ((t + 1) % 10 == 9) ? 1'b1 : 1'b0;
                tx_data = 10'h3FF;
            end
            check("R8 first pattern word after reset", 32'(rx), 32'(pexp));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule